// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the write-path controller of a serial NOR flash slave for the auto-incrementing word programming mode. An SPI front end delivers each received byte as a one-cycle strobe, together with the level of the active-low chip select. The block gathers each framed command, meaning the bytes between a falling and a rising edge of chip select. It decides on the rising edge whether the command starts a two-byte program into a small internal byte array. It keeps the write-enable and auto-increment status bits, runs a cycle counter that stands for the program time, and can turn the serial output into a ready/busy line while a program is under way.

A session opens with an opcode that carries a 24-bit start address and two data bytes. Each later command in the session carries two data bytes and no address, and writes the next word. The session ends on a write-disable command, or by itself once the word just written touches the highest unprotected address. There is no wrap-around. Programming can only clear bits. A read port on the array serves the read path.

Top module: `aai_word_seq`

## Requirements
- R1: After reset, busy, wel, aai and so_oe are 0 and every array byte reads 8'hFF; rd_data shows the byte at rd_addr one clock after rd_addr is applied.
- R2: Outside a session, a command made of the single byte 8'h06 sets wel and one made of the single byte 8'h04 clears it. A command acts only when its chip-select rising edge is sampled, and its first byte is the opcode.
- R3: A command of exactly six bytes, 8'hAD, three address bytes MSB first (only the low ADDR_W bits are used) and data bytes D0 and D1, opens a session when wel=1, busy=0 and the start word is unprotected. D0 is written to the address with bit 0 cleared, D1 to that address with bit 0 set, and aai becomes 1.
- R4: Inside a session, a command of exactly three bytes, 8'hAD, D0 and D1, writes the next word: the two addresses after the previous word.
- R5: Programming stores the bitwise AND of the new data and the byte already in the array.
- R6: busy is 1 for exactly PROG_CYCLES clocks, starting the clock after the chip-select rise that starts a program. A program command that arrives while busy=1 is ignored and does not advance the address.
- R7: Inside a session only 8'hAD and 8'h04 act. Every other opcode, including 8'h02, 8'h06 and 8'h70, has no effect.
- R8: 8'h04 inside a session clears aai and wel at once, and a program already running still completes.
- R9: When the word just started ends at or above the protection limit (the word's address plus 2 is at or above the limit), aai and wel clear on that same edge and the session does not wrap.
- R10: prot_lvl sets the protected region: 0 none, 1 upper quarter, 2 upper half, 3 the whole array. A session start with wel=0, or with its start word inside the region, is ignored.
- R11: A command with fewer or more bytes than its form needs is discarded, and no program starts.
- R12: After the single-byte command 8'h70, outside a session, so_oe is 1 on the clock after chip select is sampled low while aai or busy is 1, and so_rdy shows the inverse of busy (0 means busy). When chip select goes high, so_oe returns to 0. 8'h80 turns the feature off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select level from the front end, active low |
| byte_vld | input | 1 | One-cycle strobe: a full byte has been shifted in |
| byte_data | input | 8 | The received byte |
| prot_lvl | input | 2 | Block protection level from the status register |
| rd_addr | input | ADDR_W | Read address of the array read port |
| rd_data | output | 8 | Array byte at rd_addr, one clock later |
| busy | output | 1 | Program timer running |
| wel | output | 1 | Write-enable status bit |
| aai | output | 1 | Auto-increment session status bit |
| so_oe | output | 1 | Serial output driven by the ready/busy function |
| so_rdy | output | 1 | Ready/busy level on the serial output, 1 = ready |

## Verification
The bench issues a second word command while the first is still programming. A design that failed to ignore it would lose data or skip an address, and the read-back two words later shows which. It sends write-disable during a running program: a design that aborted the program would leave the word erased, and one that waited would keep aai high too long. It ends a session on a protection limit, where a design that wraps or carries on would go on writing past the limit. It also sends short commands, non-session opcodes inside a session, and a start inside a protected region. Each of these must leave both the array and the status bits untouched.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam logic [7:0] OP_WORD     = 8'hAD;
  localparam logic [7:0] OP_WREN     = 8'h06;
  localparam logic [7:0] OP_WRDI     = 8'h04;
  localparam logic [7:0] OP_RYBY_ON  = 8'h70;
  localparam logic [7:0] OP_RYBY_OFF = 8'h80;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WREN,
    ACT_WRDI,
    ACT_ENTER,
    ACT_NEXT,
    ACT_RYBY_ON,
    ACT_RYBY_OFF
  } act_e;
endpackage

// File: rtl/aai_cmd_capture.sv
module aai_cmd_capture #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic              cs_rise,
  output logic [7:0]        op,
  output logic [ADDR_W-2:0] word,
  output logic [7:0]        d0,
  output logic [7:0]        d1,
  output logic [2:0]        nbytes
);
  logic              cs_q;
  logic [ADDR_W-1:0] addr_r;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nbytes <= '0;
      op     <= '0;
      addr_r <= '0;
      d0     <= '0;
      d1     <= '0;
    end else if (cs_n) begin
      nbytes <= '0;
    end else if (byte_vld) begin
      if (nbytes == 3'd0) op <= byte_data;
      if (nbytes >= 3'd1 && nbytes <= 3'd3)
        addr_r <= (ADDR_W)'({addr_r, byte_data});
      d0 <= d1;
      d1 <= byte_data;
      if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
    end
  end

  assign word = addr_r[ADDR_W-1:1];
endmodule

// File: rtl/aai_cmd_decode.sv
module aai_cmd_decode
  import aai_pkg::*;
(
  input  logic       cs_rise,
  input  logic [7:0] op,
  input  logic [2:0] nbytes,
  input  logic       aai,
  input  logic       wel,
  input  logic       busy,
  input  logic       ent_ok,
  input  logic       nxt_ok,
  output act_e       act
);
  always_comb begin
    act = ACT_NONE;
    if (cs_rise) begin
      if (aai) begin
        if (op == OP_WORD && nbytes == 3'd3 && !busy && nxt_ok)
          act = ACT_NEXT;
        else if (op == OP_WRDI && nbytes == 3'd1)
          act = ACT_WRDI;
      end else begin
        unique case (op)
          OP_WREN:     if (nbytes == 3'd1) act = ACT_WREN;
          OP_WRDI:     if (nbytes == 3'd1) act = ACT_WRDI;
          OP_RYBY_ON:  if (nbytes == 3'd1) act = ACT_RYBY_ON;
          OP_RYBY_OFF: if (nbytes == 3'd1) act = ACT_RYBY_OFF;
          OP_WORD:     if (nbytes == 3'd6 && wel && !busy && ent_ok) act = ACT_ENTER;
          default:     act = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
  assign fire = (cnt == CW'(1));
endmodule

// File: rtl/aai_mem_bank.sv
module aai_mem_bank #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
  import aai_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [1:0]        prot_lvl,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wel,
  output logic              aai,
  output logic              so_oe,
  output logic              so_rdy
);
  localparam int WAW   = ADDR_W - 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LIM_ALL  = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W:0] LIM_QTR  = (ADDR_W+1)'(DEPTH - DEPTH / 4);
  localparam logic [ADDR_W:0] LIM_HALF = (ADDR_W+1)'(DEPTH / 2);

  logic           cs_rise;
  logic [7:0]     op, d0, d1, pd0, pd1;
  logic [WAW-1:0] cap_word, waddr, pword, word_sel;
  logic [2:0]     nbytes;
  logic [ADDR_W:0] lim, sel_byte, nxt_byte;
  logic           ent_ok, nxt_ok, end_hit, start, prog_we, ryby_en;
  act_e           act;
  logic [7:0]     ra [2];
  logic [7:0]     rb [2];
  logic           rd_sel_q;

  aai_cmd_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .cs_rise(cs_rise), .op(op), .word(cap_word), .d0(d0), .d1(d1), .nbytes(nbytes)
  );

  always_comb begin
    unique case (prot_lvl)
      2'd0:    lim = LIM_ALL;
      2'd1:    lim = LIM_QTR;
      2'd2:    lim = LIM_HALF;
      default: lim = '0;
    endcase
  end

  assign ent_ok = {1'b0, cap_word, 1'b0} < lim;
  assign nxt_ok = {1'b0, waddr, 1'b0} < lim;

  aai_cmd_decode u_dec (
    .cs_rise(cs_rise), .op(op), .nbytes(nbytes), .aai(aai), .wel(wel), .busy(busy),
    .ent_ok(ent_ok), .nxt_ok(nxt_ok), .act(act)
  );

  assign word_sel = (act == ACT_ENTER) ? cap_word : waddr;
  assign sel_byte = {1'b0, word_sel, 1'b0};
  assign nxt_byte = sel_byte + (ADDR_W+1)'(2);
  assign end_hit  = nxt_byte >= lim;
  assign start    = (act == ACT_ENTER) || (act == ACT_NEXT);

  aai_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .fire(prog_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wel     <= 1'b0;
      aai     <= 1'b0;
      ryby_en <= 1'b0;
      waddr   <= '0;
      pword   <= '0;
      pd0     <= 8'hFF;
      pd1     <= 8'hFF;
      so_oe   <= 1'b0;
      so_rdy  <= 1'b1;
    end else begin
      so_oe  <= ryby_en & ~cs_n & (aai | busy);
      so_rdy <= ~busy;
      unique case (act)
        ACT_WREN:     wel <= 1'b1;
        ACT_WRDI:     begin wel <= 1'b0; aai <= 1'b0; end
        ACT_RYBY_ON:  ryby_en <= 1'b1;
        ACT_RYBY_OFF: ryby_en <= 1'b0;
        ACT_ENTER, ACT_NEXT: begin
          pword <= word_sel;
          pd0   <= d0;
          pd1   <= d1;
          if (end_hit) begin
            aai <= 1'b0;
            wel <= 1'b0;
          end else begin
            aai   <= 1'b1;
            waddr <= word_sel + WAW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    aai_mem_bank #(.AW(WAW)) u_bank (
      .clk(clk), .a_we(prog_we), .a_addr(pword),
      .a_wdata(ra[g] & ((g == 0) ? pd0 : pd1)), .a_rdata(ra[g]),
      .b_addr(rd_addr[ADDR_W-1:1]), .b_rdata(rb[g])
    );
  end

  always_ff @(posedge clk) rd_sel_q <= rd_addr[0];
  assign rd_data = rd_sel_q ? rb[1] : rb[0];
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic busy,
  input logic wel,
  input logic aai,
  input logic so_oe,
  input logic prog_we
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  p_session_wel_r3: assert property (@(posedge clk) disable iff (rst)
    aai |-> wel);

  p_busy_length_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == PROG_CYCLES);

  p_write_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    prog_we |-> busy);

  p_so_needs_select_r12: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(!cs_n));

  p_start_on_rise_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_n) && $past(wel));
endmodule

bind aai_word_seq aai_word_seq_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .busy(busy), .wel(wel), .aai(aai),
  .so_oe(so_oe), .prog_we(prog_we)
);

// File: tb/aai_word_seq_test.sv
`timescale 1ns/100ps
module aai_word_seq_test;
  localparam int AW = 6;
  localparam int P  = 40;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic [1:0] prot_lvl = 2'd0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, wel, aai, so_oe, so_rdy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  aai_word_seq #(.ADDR_W(AW), .PROG_CYCLES(P)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .prot_lvl(prot_lvl), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .wel(wel), .aai(aai), .so_oe(so_oe), .so_rdy(so_rdy)
  );

  // behavioural reference model
  int m_cnt, m_word, m_pw, m_lim;
  bit m_wel, m_aai, m_ryby, m_oe, m_rdy, m_csq, m_wasb, m_rise;
  logic [7:0] m_p0, m_p1;
  logic [7:0] m_q[$];
  logic [7:0] m_mem [DEPTH];

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;

  task automatic m_start(input int w, input logic [7:0] a, input logic [7:0] b);
    m_pw = w; m_p0 = a; m_p1 = b; m_cnt = P;
    if (w * 2 + 2 >= m_lim) begin m_aai = 0; m_wel = 0; end
    else begin m_aai = 1; m_word = w + 1; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_wel = 0; m_aai = 0; m_ryby = 0; m_oe = 0; m_rdy = 1;
      m_csq = 1; m_word = 0; m_q.delete();
    end else begin
      m_wasb = (m_cnt != 0);
      m_oe = m_ryby && !cs_n && (m_aai || m_wasb);
      m_rdy = !m_wasb;
      if (m_cnt != 0) begin
        if (m_cnt == 1) begin
          m_mem[m_pw*2]   = m_mem[m_pw*2] & m_p0;
          m_mem[m_pw*2+1] = m_mem[m_pw*2+1] & m_p1;
        end
        m_cnt = m_cnt - 1;
      end
      m_lim = (prot_lvl == 0) ? DEPTH : (prot_lvl == 1) ? DEPTH * 3 / 4 :
              (prot_lvl == 2) ? DEPTH / 2 : 0;
      m_rise = cs_n && !m_csq;
      if (m_rise) begin
        if (m_aai) begin
          if (m_q.size() == 3 && m_q[0] == 8'hAD && !m_wasb && m_word * 2 < m_lim)
            m_start(m_word, m_q[1], m_q[2]);
          else if (m_q.size() == 1 && m_q[0] == 8'h04) begin m_aai = 0; m_wel = 0; end
        end else if (m_q.size() == 1) begin
          if (m_q[0] == 8'h06) m_wel = 1;
          if (m_q[0] == 8'h04) m_wel = 0;
          if (m_q[0] == 8'h70) m_ryby = 1;
          if (m_q[0] == 8'h80) m_ryby = 0;
        end else if (m_q.size() == 6 && m_q[0] == 8'hAD && m_wel && !m_wasb) begin
          if ((({16'd0, m_q[3]} % DEPTH) / 2) * 2 < m_lim)
            m_start(({16'd0, m_q[3]} % DEPTH) / 2, m_q[4], m_q[5]);
        end
      end
      if (cs_n) m_q.delete();
      else if (byte_vld) m_q.push_back(byte_data);
      m_csq = cs_n;
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R6 busy", busy, m_cnt != 0);
      cmp("R2 wel", wel, m_wel);
      cmp("R3 aai", aai, m_aai);
      cmp("R12 so_oe", so_oe, m_oe);
      if (m_oe) cmp("R12 so_rdy", so_rdy, m_rdy);
    end
  end

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b [8], input int n);
    @(posedge clk); #1 cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 byte_vld = 1'b1; byte_data = b[i];
      @(posedge clk); #1 byte_vld = 1'b0;
    end
    @(posedge clk); #1 cs_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic op1(input logic [7:0] o);
    send('{o, 0, 0, 0, 0, 0, 0, 0}, 1);
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic rd(input string tag, input int a, input logic [7:0] exp);
    @(posedge clk); #1 rd_addr = AW'(a);
    @(posedge clk); #1;
    chk8(tag, rd_data, exp);
    chk8({tag, " model"}, rd_data, m_mem[a]);
  endtask

  task automatic hold_cs(input int n);
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R1 reset state
    chk8("R1 busy", {7'd0, busy}, 8'd0);
    chk8("R1 wel", {7'd0, wel}, 8'd0);
    chk8("R1 aai", {7'd0, aai}, 8'd0);
    chk8("R1 so_oe", {7'd0, so_oe}, 8'd0);
    rd("R1 erased", 0, 8'hFF);
    // R2 write enable and disable
    op1(8'h06); chk8("R2 wren", {7'd0, wel}, 8'd1);
    op1(8'h04); chk8("R2 wrdi", {7'd0, wel}, 8'd0);
    op1(8'h06);
    // R3 session start at 0x10
    send('{8'hAD, 8'h00, 8'h00, 8'h10, 8'hA5, 8'h3C, 0, 0}, 6);
    chk8("R6 busy after start", {7'd0, busy}, 8'd1);
    chk8("R3 aai set", {7'd0, aai}, 8'd1);
    wait_idle();
    rd("R3 even byte", 16'h10, 8'hA5);
    rd("R3 odd byte", 16'h11, 8'h3C);
    // R4 next word
    send('{8'hAD, 8'h0F, 8'hF0, 0, 0, 0, 0, 0}, 3);
    wait_idle();
    rd("R4 next even", 16'h12, 8'h0F);
    rd("R4 next odd", 16'h13, 8'hF0);
    // R7 foreign opcodes inside a session
    send('{8'h02, 8'h00, 8'h00, 8'h14, 8'h99, 0, 0, 0}, 5);
    op1(8'h70);
    hold_cs(3);
    chk8("R7 ryby not enabled", {7'd0, so_oe}, 8'd0);
    #0 cs_n = 1'b1; @(posedge clk); #1;
    chk8("R7 aai kept", {7'd0, aai}, 8'd1);
    rd("R7 no byte program", 16'h14, 8'hFF);
    // R11 short word command
    send('{8'hAD, 8'h77, 0, 0, 0, 0, 0, 0}, 2);
    chk8("R11 no busy", {7'd0, busy}, 8'd0);
    rd("R11 untouched", 16'h14, 8'hFF);
    // R6 command during busy is ignored
    send('{8'hAD, 8'h11, 8'h22, 0, 0, 0, 0, 0}, 3);
    send('{8'hAD, 8'h33, 8'h44, 0, 0, 0, 0, 0}, 3);
    wait_idle();
    send('{8'hAD, 8'h55, 8'h66, 0, 0, 0, 0, 0}, 3);
    wait_idle();
    rd("R6 first word", 16'h14, 8'h11);
    rd("R6 ignored word skipped", 16'h16, 8'h55);
    rd("R6 ignored word odd", 16'h17, 8'h66);
    // R8 exit during running program
    send('{8'hAD, 8'h77, 8'h88, 0, 0, 0, 0, 0}, 3);
    op1(8'h04);
    chk8("R8 aai cleared", {7'd0, aai}, 8'd0);
    chk8("R8 wel cleared", {7'd0, wel}, 8'd0);
    chk8("R8 still busy", {7'd0, busy}, 8'd1);
    wait_idle();
    rd("R8 program completed", 16'h18, 8'h77);
    rd("R8 program completed odd", 16'h19, 8'h88);
    // R5 AND into existing data, odd start address aligns down (R3)
    op1(8'h06);
    send('{8'hAD, 8'h00, 8'h00, 8'h11, 8'hF0, 8'h0F, 0, 0}, 6);
    wait_idle();
    rd("R5 and even", 16'h10, 8'hA0);
    rd("R5 and odd", 16'h11, 8'h0C);
    op1(8'h04);
    // R10 protected start and missing enable
    prot_lvl = 2'd1;
    op1(8'h06);
    send('{8'hAD, 8'h00, 8'h00, 8'h30, 8'h12, 8'h34, 0, 0}, 6);
    chk8("R10 protected no busy", {7'd0, busy}, 8'd0);
    chk8("R10 protected no aai", {7'd0, aai}, 8'd0);
    rd("R10 protected untouched", 16'h30, 8'hFF);
    op1(8'h04);
    send('{8'hAD, 8'h00, 8'h00, 8'h20, 8'h12, 8'h34, 0, 0}, 6);
    chk8("R10 no wel no busy", {7'd0, busy}, 8'd0);
    rd("R10 no wel untouched", 16'h20, 8'hFF);
    // R12 ready/busy on SO and R9 end at limit
    op1(8'h70);
    op1(8'h06);
    send('{8'hAD, 8'h00, 8'h00, 8'h2C, 8'h01, 8'h02, 0, 0}, 6);
    hold_cs(3);
    chk8("R12 drive while busy", {7'd0, so_oe}, 8'd1);
    chk8("R12 busy level", {7'd0, so_rdy}, 8'd0);
    #0 cs_n = 1'b1; @(posedge clk); #1; @(posedge clk); #1;
    chk8("R12 released", {7'd0, so_oe}, 8'd0);
    wait_idle();
    hold_cs(3);
    chk8("R12 ready level", {7'd0, so_rdy}, 8'd1);
    #0 cs_n = 1'b1; @(posedge clk); #1;
    send('{8'hAD, 8'h03, 8'h04, 0, 0, 0, 0, 0}, 3);
    chk8("R9 aai cleared at limit", {7'd0, aai}, 8'd0);
    chk8("R9 wel cleared at limit", {7'd0, wel}, 8'd0);
    wait_idle();
    rd("R9 last word", 16'h2E, 8'h03);
    rd("R9 last word odd", 16'h2F, 8'h04);
    rd("R9 no wrap", 16'h30, 8'hFF);
    rd("R9 no wrap low", 16'h00, 8'hFF);
    // R12 disable
    op1(8'h80);
    op1(8'h06);
    send('{8'hAD, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hC3, 0, 0}, 6);
    hold_cs(3);
    chk8("R12 disabled", {7'd0, so_oe}, 8'd0);
    #0 cs_n = 1'b1; @(posedge clk); #1;
    wait_idle();
    rd("R3 low word", 16'h00, 8'h5A);
    finish_run();
  end
endmodule